// File: doc/BRIEF.md
# Configurable Ready/Busy Status Pin Controller

This block drives an open-drain status pin that tells a host when erase and program operations finish. It watches two activity flags, one for erase and one for program, and turns them into a pin drive-low enable plus its complementary high-impedance release.

A configuration code, loaded with a one-cycle strobe, chooses the behaviour. In level mode the pin is pulled low for as long as either operation runs. In the three pulse modes the pin stays released while work is in progress. It then pulls low for a fixed number of clock cycles when an erase completes, when a program completes, or when either completes. The pulse width is a parameter in clock cycles, chosen so that the pulse lasts about 250 ns at the system clock.

Command decoding and the memory operations themselves sit outside this block.

Top module: `sts_pin_ctrl`

## Requirements
- R1: After reset the mode is level (code 0) and, with both activity flags low, the pin is released: `pin_low_o`=0 and `pin_hiz_o`=1.
- R2: With mode code 0, `pin_low_o` is 1 in every cycle in which `erase_busy_i` or `prog_busy_i` is 1, and 0 otherwise.
- R3: With mode code 1, a pulse starts only when `erase_busy_i` falls. A falling `prog_busy_i` starts none.
- R4: With mode code 2, a pulse starts only when `prog_busy_i` falls. A falling `erase_busy_i` starts none.
- R5: With mode code 3, a falling edge on either activity flag starts a pulse.
- R6: A pulse drives `pin_low_o` high for exactly `PULSE_CYC` cycles. It begins with the first clock edge that sees the activity flag low after it was high.
- R7: Only bits [1:0] of `cfg_code_i` select the mode. Bits above them have no effect.
- R8: A completion that counts in the current mode and arrives during a pulse restarts the pulse for a full `PULSE_CYC` cycles from that edge.
- R9: A code loaded while a pulse runs is held. It takes effect at the first clock edge after the pulse ends. A code loaded with no pulse running takes effect at the loading edge.
- R10: `pin_hiz_o` is always the complement of `pin_low_o`.
- R11: In modes 1 to 3, the activity flags themselves never pull the pin low. Only pulses do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_code_i | input | CODE_W | Configuration code; bits [1:0] select the mode |
| cfg_load_i | input | 1 | One-cycle strobe that loads `cfg_code_i` |
| erase_busy_i | input | 1 | High while a block erase runs |
| prog_busy_i | input | 1 | High while a program operation runs |
| pin_low_o | output | 1 | Enable that drives the status pin low |
| pin_hiz_o | output | 1 | Status pin released (high impedance) |

## Verification
A wrong internal state shows up as a pin level that differs from the reference model, and it does so within one clock. A stale mode makes the pin follow the activity flags in a pulse mode, or ignore them in level mode, in the cycle after the load. A miscounting timer ends a pulse one or more cycles early or late, and this appears at the last cycle of the first pulse. A lost previous-flag value either fires a pulse where none should be or misses one, and this appears in the cycle after the flag falls. A pending code applied at the wrong moment changes the pin in the very cycle the deferred load should still be waiting.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'd0,
    MODE_ERASE = 2'd1,
    MODE_PROG  = 2'd2,
    MODE_ANY   = 2'd3
  } sts_mode_e;
endpackage

// File: rtl/sts_fall_det.sv
module sts_fall_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flag_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= flag_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_fall
    assign fall_o[i] = prev_q[i] & ~flag_i[i];
  end
endmodule

// File: rtl/sts_mode_reg.sv
module sts_mode_reg
  import sts_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] code_i,
  input  logic       load_i,
  input  logic       pulse_act_i,
  output sts_mode_e  mode_o
);
  sts_mode_e mode_q, pend_q;
  logic      pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_LEVEL;
      pend_q   <= MODE_LEVEL;
      pend_v_q <= 1'b0;
    end else if (load_i && !pulse_act_i) begin
      mode_q   <= sts_mode_e'(code_i);
      pend_v_q <= 1'b0;
    end else if (load_i) begin
      // defer until the running pulse ends
      pend_q   <= sts_mode_e'(code_i);
      pend_v_q <= 1'b1;
    end else if (pend_v_q && !pulse_act_i) begin
      mode_q   <= pend_q;
      pend_v_q <= 1'b0;
    end
  end

  assign mode_o = mode_q;

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_act_i |=> $stable(mode_o));
endmodule

// File: rtl/sts_pulse_timer.sv
module sts_pulse_timer #(
  parameter int unsigned PULSE_CYC = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic act_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (fire_i)         cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign act_o = (cnt_q != '0);

  // R6
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LOAD);

  // R8
  pulse_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (cnt_q == CNT_LOAD));
endmodule

// File: rtl/sts_pin_ctrl.sv
module sts_pin_ctrl
  import sts_pkg::*;
#(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned PULSE_CYC = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic              cfg_load_i,
  input  logic              erase_busy_i,
  input  logic              prog_busy_i,
  output logic              pin_low_o,
  output logic              pin_hiz_o
);
  localparam int unsigned ERASE_IDX = 0;
  localparam int unsigned PROG_IDX  = 1;

  sts_mode_e  mode;
  logic [1:0] fall;
  logic       fire, pulse_act, level_low;
  logic       unused_upper;

  assign unused_upper = ^cfg_code_i[CODE_W-1:2];

  sts_fall_det #(.N(2)) i_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i ({prog_busy_i, erase_busy_i}),
    .fall_o (fall)
  );

  sts_mode_reg i_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .code_i      (cfg_code_i[1:0]),
    .load_i      (cfg_load_i),
    .pulse_act_i (pulse_act),
    .mode_o      (mode)
  );

  // mode bit 0 enables erase completion, bit 1 program completion
  assign fire = (mode[0] & fall[ERASE_IDX]) | (mode[1] & fall[PROG_IDX]);

  sts_pulse_timer #(.PULSE_CYC(PULSE_CYC)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .act_o  (pulse_act)
  );

  assign level_low = (mode == MODE_LEVEL) & (erase_busy_i | prog_busy_i);
  assign pin_low_o = pulse_act | level_low;
  assign pin_hiz_o = ~pin_low_o;

  // R2
  level_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode == MODE_LEVEL) && (erase_busy_i || prog_busy_i)) |-> pin_low_o);

  // R11
  pulse_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode != MODE_LEVEL) && !pulse_act) |-> !pin_low_o);

  // R10
  hiz_compl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_hiz_o != pin_low_o);
endmodule

// File: tb/test_sts_pin_ctrl.sv
module test_sts_pin_ctrl;
  localparam int CLK_NS    = 10;
  localparam int PULSE_CYC = 250 / CLK_NS;
  localparam int CODE_W    = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CODE_W-1:0] code = '0;
  logic              load = 1'b0;
  logic              erase = 1'b0;
  logic              prog = 1'b0;
  logic              pin_low, pin_hiz;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  // reference model state
  int m_mode = 0, m_pend = 0, m_cnt = 0;
  bit m_pend_v = 0, m_prev_e = 0, m_prev_p = 0;

  always #(CLK_NS/2) clk = ~clk;

  sts_pin_ctrl #(.CODE_W(CODE_W), .PULSE_CYC(PULSE_CYC)) i_sts_pin_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_code_i(code), .cfg_load_i(load),
    .erase_busy_i(erase), .prog_busy_i(prog),
    .pin_low_o(pin_low), .pin_hiz_o(pin_hiz)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_pend = 0; m_pend_v = 0; m_cnt = 0; m_prev_e = 0; m_prev_p = 0;
    end else begin
      bit act, fe, fp, fire;
      act  = (m_cnt > 0);
      fe   = m_prev_e && !erase;
      fp   = m_prev_p && !prog;
      fire = (fe && (m_mode == 1 || m_mode == 3)) || (fp && (m_mode == 2 || m_mode == 3));
      if (fire) m_cnt = PULSE_CYC;
      else if (m_cnt > 0) m_cnt--;
      if (load && !act) begin
        m_mode = code % 4; m_pend_v = 0;
      end else if (load) begin
        m_pend = code % 4; m_pend_v = 1;
      end else if (m_pend_v && !act) begin
        m_mode = m_pend; m_pend_v = 0;
      end
      m_prev_e = erase; m_prev_p = prog;
    end
  end

  function automatic bit exp_low();
    return (m_cnt > 0) || (m_mode == 0 && (erase || prog));
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (pin_low !== exp_low()) begin
        n_fail++;
        $display("FAIL %s: pin_low_o=%0b expected %0b at %0t", cur_req, pin_low, exp_low(), $time);
      end
      n_chk++;
      if (pin_hiz !== !exp_low()) begin
        n_fail++;
        $display("FAIL R10: pin_hiz_o=%0b expected %0b at %0t", pin_hiz, !exp_low(), $time);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic load_cfg(logic [CODE_W-1:0] c);
    code = c; load = 1'b1;
    step(1);
    load = 1'b0;
  endtask

  task automatic op(bit is_erase, int len);
    if (is_erase) erase = 1'b1; else prog = 1'b1;
    step(len);
    if (is_erase) erase = 1'b0; else prog = 1'b0;
  endtask

  initial begin
    step(3);
    // R1: reset state, checked while still in reset
    n_chk++;
    if (pin_low !== 1'b0 || pin_hiz !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: low/hiz=%0b%0b expected 01", pin_low, pin_hiz);
    end
    rst_n = 1'b1;
    step(2);
    cur_req = "R2";
    op(1, 5); step(3);
    op(0, 7); step(3);
    erase = 1; step(2); prog = 1; step(2); erase = 0; step(2); prog = 0; step(3);
    cur_req = "R7";                      // upper bits set, mode 1
    load_cfg(8'hFD); step(2);
    cur_req = "R3";
    op(1, 4); step(PULSE_CYC + 3);
    op(0, 4); step(PULSE_CYC + 3);
    cur_req = "R4";
    load_cfg(8'h02);
    op(1, 4); step(PULSE_CYC + 3);
    op(0, 6); step(PULSE_CYC + 3);
    cur_req = "R5";
    load_cfg(8'h03);
    op(1, 3); step(PULSE_CYC + 3);
    op(0, 3); step(PULSE_CYC + 3);
    cur_req = "R11";
    erase = 1; prog = 1; step(8); erase = 0; prog = 0; step(PULSE_CYC + 3);
    cur_req = "R8";
    op(0, 3); step(10); op(1, 2); step(PULSE_CYC + 3);
    cur_req = "R6";
    op(1, 2); step(PULSE_CYC - 1); step(4);
    cur_req = "R9";
    op(1, 2); step(4);
    load_cfg(8'h00);                      // deferred during pulse
    prog = 1; step(PULSE_CYC + 4); prog = 0; step(3);
    load_cfg(8'h01); op(0, 3); step(4);   // immediate load, prog ignored
    step(5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule